// File: doc/BRIEF.md
# Single-Frame Transmit Mailbox

This block is the transmit side of a small host-driven network port. It holds at most one outgoing frame. Software fills a word buffer by writing 32-bit words, one after another, to a single data port address. It then writes the control register with the frame's byte count and the start bit set. The block sends the stored bytes to a MAC-side byte stream that uses a valid/ready handshake and marks the final byte with `last`. When the frame is done, the block reports the result in the control register and can raise an edge interrupt.

The start bit also serves as the busy flag. It reads 1 while the frame is being sent, and hardware clears it when sending finishes, whether the frame succeeded or failed. Software writes the control register with the start bit at 0 to acknowledge completion. This clears the status and returns the buffer's write pointer to word 0, so the next frame loads from the beginning. Preamble, padding and CRC are added downstream and are not part of this block.

Register map (word addresses on `reg_wr_addr` / `reg_rd_addr`): 0 is the data port (write only, reads as 0). 1 is the control register: bit 0 is start/busy, bit 1 is the error flag, and bits 31:16 are the byte count. 2 is the interrupt enable: bit 0 enables the transmit-done interrupt.

Top module: `txmb_top`

## Requirements
- R1: After reset the control register and the interrupt-enable register read 0, `irq_tx_done` is 0, `mac_valid` is 0, and address 0 reads as 0.
- R2: A control write with bit 0 = 1 and a byte count N (bits 31:16), where 1 <= N <= 4*DEPTH, starts a frame. From the next cycle until completion, bit 0 reads 1 and `mac_valid` is 1. On success, bit 0 clears, bit 1 reads 0 and the count field reads N.
- R3: Byte k of the frame is byte lane k mod 4 of stored word k/4. Lane 0 is bits 31:24, and lanes go from most-significant to least-significant. Exactly N bytes are sent, so the final word gives N mod 4 bytes, or 4 bytes when the remainder is 0. `mac_last` is 1 only with byte N-1.
- R4: While `mac_valid` is 1 and `mac_ready` is 0, with no abort, the byte, `mac_valid` and `mac_last` hold steady into the next cycle.
- R5: If `mac_abort` is 1 in a sending cycle in which the final byte is not accepted, the frame ends. Bit 0 clears, bit 1 sets, and the count field reports the bytes accepted, including one accepted in that same cycle. If the abort coincides with acceptance of the final byte, the frame completes successfully.
- R6: A start with N = 0 or N > 4*DEPTH completes in the same write. Bit 0 never reads 1, bit 1 reads 1, the count reads 0, no byte is sent, and a completion event occurs.
- R7: A control write with bit 0 = 0, made while not busy, clears bit 1 and the count field and resets the write pointer. Words written afterwards fill the buffer from word 0.
- R8: While bit 0 reads 1, writes to the data port and to the control register are ignored. A frame restarted afterwards without an acknowledge sends the earlier words plus only the words written while not busy.
- R9: On each completion (success, abort or rejected length), `irq_tx_done` is 1 for exactly the next cycle if the enable bit was 1. A completion that happens while the enable is 0 never produces an interrupt, even if the enable is set later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Host register write strobe |
| reg_wr_addr | input | 2 | Host write word address |
| reg_wr_data | input | 32 | Host write data |
| reg_rd_addr | input | 2 | Host read word address |
| reg_rd_data | output | 32 | Host read data (combinational) |
| mac_data | output | 8 | Frame byte to the MAC |
| mac_valid | output | 1 | Byte is valid |
| mac_last | output | 1 | Byte is the final byte of the frame |
| mac_ready | input | 1 | MAC accepts the byte this cycle |
| mac_abort | input | 1 | MAC aborts the frame in progress |
| irq_tx_done | output | 1 | One-cycle transmit-done interrupt pulse |

## Verification
The delicate collision is an abort from the MAC in the same cycle that the final byte is accepted. Both paths want to end the frame, but with different status. The bench stalls `mac_ready` by hand, releases it one byte at a time, and raises `mac_abort` exactly in the cycle of the last handshake. It expects a clean completion with the full count and no error flag. It also aborts a frame mid-way to confirm the opposite outcome, where the error flag is set and the count reports the partial byte total.

// File: rtl/txmb_pkg.sv
package txmb_pkg;
  localparam int CNT_W = 16;
  localparam logic [1:0] A_DATA  = 2'd0;
  localparam logic [1:0] A_CTRL  = 2'd1;
  localparam logic [1:0] A_IRQEN = 2'd2;

  // number of 32-bit words needed for n bytes
  function automatic logic [CNT_W-1:0] words_for_len(input logic [CNT_W-1:0] n);
    logic [CNT_W:0] t;
    t = {1'b0, n} + (CNT_W+1)'(3);
    return t[CNT_W:2];
  endfunction

  // lane 0 is the most significant byte
  function automatic logic [7:0] byte_lane(input logic [31:0] w, input logic [1:0] lane);
    return w[8*(3-int'(lane)) +: 8];
  endfunction

  function automatic logic [31:0] ctrl_word(input logic start, input logic err,
                                            input logic [CNT_W-1:0] cnt);
    return {cnt, 14'd0, err, start};
  endfunction
endpackage

// File: rtl/txmb_wordbuf.sv
module txmb_wordbuf #(
  parameter int DEPTH = 384,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [31:0]      wdata,
  input  logic             lock,
  input  logic             clear,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_word
);
  logic [31:0]      mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic             wr_take;

  assign wr_take = wr && !lock && (wr_ptr < PTR_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (wr_take) mem[wr_ptr[IDX_W-1:0]] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wr_ptr <= '0;
    else if (clear)   wr_ptr <= '0;
    else if (wr_take) wr_ptr <= wr_ptr + PTR_W'(1);
  end

  assign rd_word = mem[rd_idx];

  // R8: the pointer is frozen while a frame is in flight
  a_r8_ptr_locked: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(wr_ptr));
endmodule

// File: rtl/txmb_streamer.sv
module txmb_streamer
  import txmb_pkg::*;
#(
  parameter int DEPTH = 384,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [CNT_W-1:0] launch_len,
  input  logic [31:0]      word_in,
  output logic [IDX_W-1:0] word_idx,
  output logic [7:0]       tx_data,
  output logic             tx_valid,
  output logic             tx_last,
  input  logic             tx_ready,
  input  logic             tx_abort,
  output logic             fin_ok,
  output logic             fin_err,
  output logic [CNT_W-1:0] sent_cnt
);
  logic             active;
  logic [CNT_W-1:0] bidx;
  logic [CNT_W-1:0] len_q;
  logic             hs;

  assign word_idx = bidx[IDX_W+1:2];
  assign tx_data  = byte_lane(word_in, bidx[1:0]);
  assign tx_valid = active;
  assign tx_last  = active && (bidx == len_q - CNT_W'(1));
  assign hs       = active && tx_ready;
  assign fin_ok   = hs && tx_last;
  assign fin_err  = active && tx_abort && !fin_ok;
  assign sent_cnt = fin_ok ? len_q : bidx + CNT_W'(hs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      bidx   <= '0;
      len_q  <= '0;
    end else if (launch) begin
      active <= 1'b1;
      bidx   <= '0;
      len_q  <= launch_len;
    end else if (fin_ok || fin_err) begin
      active <= 1'b0;
    end else if (hs) begin
      bidx <= bidx + CNT_W'(1);
    end
  end

  // R3: the byte index never runs past the frame length
  a_r3_index_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (bidx < len_q));
  // R5: an abort always terminates the frame
  a_r5_abort_ends: assert property (@(posedge clk) disable iff (!rst_n)
    fin_err |=> !active);
endmodule

// File: rtl/txmb_csr.sv
module txmb_csr
  import txmb_pkg::*;
#(
  parameter int DEPTH = 384
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             ie_wr,
  input  logic             wr_start_bit,
  input  logic [CNT_W-1:0] wr_len,
  input  logic             wr_ie_bit,
  input  logic             fin_ok,
  input  logic             fin_err,
  input  logic [CNT_W-1:0] sent_cnt,
  input  logic [1:0]       rd_addr,
  output logic [31:0]      rd_data,
  output logic             busy,
  output logic             launch,
  output logic             ack,
  output logic             irq
);
  localparam logic [CNT_W-1:0] DEPTH_W = CNT_W'(DEPTH);

  logic             start_q, err_q, ie_q, irq_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ctrl_take, len_ok, reject, done_evt;

  assign ctrl_take = ctrl_wr && !start_q;
  assign len_ok    = (wr_len != '0) && (words_for_len(wr_len) <= DEPTH_W);
  assign launch    = ctrl_take && wr_start_bit && len_ok;
  assign reject    = ctrl_take && wr_start_bit && !len_ok;
  assign ack       = ctrl_take && !wr_start_bit;
  assign done_evt  = fin_ok || fin_err || reject;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      err_q   <= 1'b0;
      cnt_q   <= '0;
    end else if (launch) begin
      start_q <= 1'b1;
      err_q   <= 1'b0;
      cnt_q   <= wr_len;
    end else if (reject) begin
      err_q   <= 1'b1;
      cnt_q   <= '0;
    end else if (ack) begin
      err_q   <= 1'b0;
      cnt_q   <= '0;
    end else if (fin_ok || fin_err) begin
      start_q <= 1'b0;
      err_q   <= fin_err;
      cnt_q   <= sent_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (ie_wr) ie_q <= wr_ie_bit;
      irq_q <= done_evt && ie_q;
    end
  end

  always_comb begin
    unique case (rd_addr)
      A_CTRL:  rd_data = ctrl_word(start_q, err_q, cnt_q);
      A_IRQEN: rd_data = {31'd0, ie_q};
      default: rd_data = '0;
    endcase
  end

  assign busy = start_q;
  assign irq  = irq_q;

  // R9: an interrupt only follows a cycle in which the enable was set
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ie_q));
  // R9: interrupt is a single-cycle pulse
  a_r9_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R6: rejected length completes without ever showing busy
  a_r6_reject_err: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (err_q && !start_q && cnt_q == '0));
  // R5: abort leaves the error flag set and the busy flag clear
  a_r5_abort_flag: assert property (@(posedge clk) disable iff (!rst_n)
    fin_err |=> (err_q && !start_q));
endmodule

// File: rtl/txmb_top.sv
module txmb_top
  import txmb_pkg::*;
#(
  parameter int DEPTH = 384,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [1:0]  reg_wr_addr,
  input  logic [31:0] reg_wr_data,
  input  logic [1:0]  reg_rd_addr,
  output logic [31:0] reg_rd_data,
  output logic [7:0]  mac_data,
  output logic        mac_valid,
  output logic        mac_last,
  input  logic        mac_ready,
  input  logic        mac_abort,
  output logic        irq_tx_done
);
  logic             busy, launch, ack;
  logic             fin_ok, fin_err;
  logic [CNT_W-1:0] sent_cnt;
  logic [IDX_W-1:0] word_idx;
  logic [31:0]      word_rd;
  logic             data_wr, ctrl_wr, ie_wr;

  assign data_wr = reg_wr_en && (reg_wr_addr == A_DATA);
  assign ctrl_wr = reg_wr_en && (reg_wr_addr == A_CTRL);
  assign ie_wr   = reg_wr_en && (reg_wr_addr == A_IRQEN);

  txmb_wordbuf #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr(data_wr), .wdata(reg_wr_data),
    .lock(busy), .clear(ack), .rd_idx(word_idx), .rd_word(word_rd)
  );

  txmb_streamer #(.DEPTH(DEPTH)) u_str (
    .clk(clk), .rst_n(rst_n), .launch(launch),
    .launch_len(reg_wr_data[31:16]), .word_in(word_rd), .word_idx(word_idx),
    .tx_data(mac_data), .tx_valid(mac_valid), .tx_last(mac_last),
    .tx_ready(mac_ready), .tx_abort(mac_abort),
    .fin_ok(fin_ok), .fin_err(fin_err), .sent_cnt(sent_cnt)
  );

  txmb_csr #(.DEPTH(DEPTH)) u_csr (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ie_wr(ie_wr),
    .wr_start_bit(reg_wr_data[0]), .wr_len(reg_wr_data[31:16]),
    .wr_ie_bit(reg_wr_data[0]), .fin_ok(fin_ok), .fin_err(fin_err),
    .sent_cnt(sent_cnt), .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
    .busy(busy), .launch(launch), .ack(ack), .irq(irq_tx_done)
  );

  // R4: stalled byte holds steady
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_valid && !mac_ready && !mac_abort) |=>
      (mac_valid && $stable(mac_data) && $stable(mac_last)));
  // R2: bytes flow only while the busy flag is set
  a_r2_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mac_valid |-> busy);
  // R3: the final-byte marker only accompanies a valid byte
  a_r3_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    mac_last |-> mac_valid);
endmodule

// File: tb/txmb_top_test.sv
`timescale 1ns/1ps
module txmb_top_test;
  localparam int DEPTH = 384;
  localparam int CAP   = 4 * DEPTH;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_wr_addr = '0;
  logic [31:0] reg_wr_data = '0;
  logic [1:0]  reg_rd_addr = '0;
  logic [31:0] reg_rd_data;
  logic [7:0]  mac_data;
  logic        mac_valid, mac_last, mac_ready;
  logic        mac_abort = 1'b0;
  logic        irq_tx_done;

  int  rmode = 0;        // 0 always ready, 1 patterned, 2 manual
  logic man_ready = 1'b0;
  logic patt = 1'b0;
  int  cyc = 0;

  assign mac_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? patt : man_ready;

  always #2 clk = ~clk;

  txmb_top #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .mac_data(mac_data), .mac_valid(mac_valid), .mac_last(mac_last),
    .mac_ready(mac_ready), .mac_abort(mac_abort), .irq_tx_done(irq_tx_done)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] cap [CAP+8];
  bit         cap_last [CAP+8];
  int         cap_n = 0;
  int         irq_n = 0;
  logic [7:0] exp_b [CAP+8];
  bit         stall_prev = 0;
  logic [7:0] stall_data = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 patt <= cyc[0] ^ cyc[2];
  end

  always @(negedge clk) begin
    if (irq_tx_done) irq_n++;
    if (stall_prev && mac_valid && mac_data !== stall_data) begin
      n_chk++; n_bad++;
      $display("FAIL R4 stalled byte changed: actual=%h expected=%h", mac_data, stall_data);
    end
    stall_prev = mac_valid && !mac_ready && !mac_abort;
    stall_data = mac_data;
    if (mac_valid && mac_ready && cap_n < CAP + 8) begin
      cap[cap_n] = mac_data;
      cap_last[cap_n] = mac_last;
      cap_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] fbyte(input int seed, input int i);
    return 8'(seed * 37 + i * 11 + (i >> 4));
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(posedge clk); #1;
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_rd_addr = a;
    #1 v = reg_rd_data;
  endtask

  // packs exp_b[from..from+4*nw-1] MSB first and writes it
  task automatic load_words(input int from, input int nw);
    for (int w = 0; w < nw; w++)
      wr(2'd0, {exp_b[from+4*w], exp_b[from+4*w+1], exp_b[from+4*w+2], exp_b[from+4*w+3]});
  endtask

  task automatic make_frame(input int seed, input int len);
    for (int i = 0; i < len + 4; i++) exp_b[i] = (i < len) ? fbyte(seed, i) : 8'hEE;
  endtask

  task automatic start(input int len);
    cap_n = 0;
    wr(2'd1, {16'(len), 15'd0, 1'b1});
  endtask

  task automatic wait_done(output logic [31:0] v);
    v = 32'h1;
    for (int k = 0; k < 6000 && v[0]; k++) rd(2'd1, v);
  endtask

  task automatic cmp_frame(input string req, input int len);
    int bad;
    chk(cap_n == len, req, "byte count on MAC side", cap_n, len);
    bad = 0;
    for (int i = 0; i < len && i < cap_n; i++)
      if (cap[i] !== exp_b[i] || cap_last[i] != (i == len - 1)) bad++;
    chk(bad == 0, "R3", "bytes/last mismatching", bad, 0);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(2'd1, v); chk(v == 0, "R1", "ctrl after reset", v, 0);
    rd(2'd2, v); chk(v == 0, "R1", "irq enable after reset", v, 0);
    rd(2'd0, v); chk(v == 0, "R1", "data port reads", v, 0);
    chk(!irq_tx_done && !mac_valid, "R1", "irq/valid after reset",
        {irq_tx_done, mac_valid}, 0);
  endtask

  task automatic t_basic(input int seed, input int len, input int mode);
    logic [31:0] v;
    int i0;
    rmode = mode;
    wr(2'd1, 32'h0);
    make_frame(seed, len);
    load_words(0, (len + 3) / 4);
    i0 = irq_n;
    start(len);
    rd(2'd1, v);
    chk(v[0] == 1'b1, "R2", "start bit while pending", v[0], 1);
    wait_done(v);
    chk(v == {16'(len), 16'd0}, "R2", "ctrl after success", v, {16'(len), 16'd0});
    repeat (3) @(posedge clk);
    cmp_frame("R3", len);
    chk(irq_n - i0 == 1, "R9", "irq pulses on completion", irq_n - i0, 1);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] v;
    rmode = 1;
    wr(2'd1, 32'h0);
    make_frame(5, 8);
    load_words(0, 2);
    start(8);
    wr(2'd0, 32'hDEADBEEF);
    wr(2'd1, 32'h0005_0001);
    wait_done(v);
    chk(v == {16'd8, 16'd0}, "R8", "ctrl write ignored while busy", v, {16'd8, 16'd0});
    repeat (2) @(posedge clk);
    cmp_frame("R8", 8);
    exp_b[8] = 8'h11; exp_b[9] = 8'h22; exp_b[10] = 8'h33; exp_b[11] = 8'h44;
    wr(2'd0, 32'h11223344);
    start(12);
    wait_done(v);
    repeat (2) @(posedge clk);
    cmp_frame("R8", 12);
    chk(cap[8] == 8'h11, "R8", "word after busy period lands in slot 2", cap[8], 8'h11);
  endtask

  task automatic t_abort;
    logic [31:0] v;
    int i0;
    rmode = 2; man_ready = 1'b0;
    wr(2'd1, 32'h0);
    make_frame(9, 20);
    load_words(0, 5);
    i0 = irq_n;
    start(20);
    man_ready = 1'b1;
    repeat (5) begin @(posedge clk); #1; end
    man_ready = 1'b0; mac_abort = 1'b1;
    @(posedge clk); #1;
    mac_abort = 1'b0;
    rd(2'd1, v);
    chk(v == {16'd5, 16'd2}, "R5", "ctrl after mid-frame abort", v, {16'd5, 16'd2});
    chk(cap_n == 5 && !mac_valid, "R5", "bytes sent before abort", cap_n, 5);
    repeat (2) @(posedge clk);
    chk(irq_n - i0 == 1, "R9", "irq on abort", irq_n - i0, 1);
    wr(2'd1, 32'h0);
    rd(2'd1, v);
    chk(v == 0, "R7", "acknowledge clears status", v, 0);
    // abort together with the last handshake
    make_frame(3, 4);
    load_words(0, 1);
    start(4);
    man_ready = 1'b1;
    repeat (3) begin @(posedge clk); #1; end
    mac_abort = 1'b1;
    @(posedge clk); #1;
    mac_abort = 1'b0; man_ready = 1'b0;
    rd(2'd1, v);
    chk(v == {16'd4, 16'd0}, "R5", "abort on last byte is success", v, {16'd4, 16'd0});
    cmp_frame("R5", 4);
  endtask

  task automatic t_reject;
    logic [31:0] v;
    int i0;
    rmode = 0;
    wr(2'd1, 32'h0);
    i0 = irq_n;
    start(0);
    rd(2'd1, v);
    chk(v == 32'h2, "R6", "zero length rejected", v, 2);
    start(CAP + 1);
    rd(2'd1, v);
    chk(v == 32'h2, "R6", "oversize length rejected", v, 2);
    repeat (2) @(posedge clk);
    chk(cap_n == 0, "R6", "no bytes for rejected start", cap_n, 0);
    chk(irq_n - i0 == 2, "R6", "rejects count as completions", irq_n - i0, 2);
  endtask

  task automatic t_irq_masked;
    logic [31:0] v;
    int i0;
    wr(2'd2, 32'h0);
    rmode = 0;
    wr(2'd1, 32'h0);
    make_frame(12, 6);
    load_words(0, 2);
    i0 = irq_n;
    start(6);
    wait_done(v);
    wr(2'd2, 32'h1);
    repeat (8) @(posedge clk);
    chk(irq_n == i0, "R9", "masked completion never interrupts", irq_n - i0, 0);
    rd(2'd2, v);
    chk(v == 1, "R9", "enable readback", v, 1);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    wr(2'd2, 32'h1);
    t_basic(1, 64, 0);      // R2 R3 R7: loads from word 0 after acknowledge
    t_basic(2, 61, 1);      // R3 remainder 1, R4 stalls
    t_basic(4, 62, 1);      // R3 remainder 2
    t_basic(6, 63, 1);      // R3 remainder 3
    t_basic(8, 1, 0);       // single byte frame
    t_busy_ignore();        // R8
    t_abort();              // R5 R7
    t_reject();             // R6
    t_basic(11, CAP, 0);    // R6 boundary: exactly full buffer succeeds
    t_irq_masked();         // R9
    finish_run();
  end
endmodule